// File: doc/BRIEF.md
# Chained Transfer Completion Controller

This block is the sequencing core of a data transfer engine. Each interrupt source can be armed so that its event starts a transfer instead of interrupting the processor. When an armed source raises its flag, the controller reads a descriptor from a small on-block store. The descriptor holds an 8-bit mode byte, a source pointer, a destination pointer and a counter. The controller then issues one modelled data move and writes the advanced pointers and the decremented counter back to the same slot.

Two bits of the mode byte decide what happens after the move. A link bit set means the next consecutive slot is fetched and moved at once, with no new request and no end-of-run handling. With the link bit clear, the descriptor is the last of the run. The controller then settles the source: it consumes the event, passes it to the processor, or disarms the source once its counter is exhausted. Requests that arrive during a run stay pending until the controller is idle again.

Top module: `chain_xfer_ctrl`

## Requirements
- R1: After reset the controller is idle (`busy` low), no move is issued, and every source flag, arm bit and processor interrupt line is low.
- R2: A source whose flag and arm bit are both set starts a run from idle. A flagged source that is not armed starts no move and drives its `cpu_irq` line high.
- R3: In the mode byte, bit 7 is the link bit and bit 6 is the interrupt-select bit. Bits 5 to 0 have no effect on the moves, flags, arm bits or interrupts.
- R4: A descriptor whose link bit is 0 ends the run after its single move, and the controller returns to idle.
- R5: A descriptor whose link bit is 1 is followed by a fetch and move of the next slot, with no new request. For such a descriptor the counter is not tested and neither the flag nor the arm bit changes, even when its counter reaches 0.
- R6: On the final descriptor, with interrupt-select 0 and a counter that has not reached 0, the source flag is cleared and `cpu_irq` stays low.
- R7: On the final descriptor, with interrupt-select 1 and a counter that has not reached 0, the flag stays set and `cpu_irq` is raised. The source is not restarted while that flag remains set.
- R8: When the final descriptor's counter reaches 0, the source's arm bit is cleared and its flag stays set, so `cpu_irq` is raised whatever the interrupt-select bit is.
- R9: Each move presents the slot's pointers as they were before the move. The slot then holds both pointers plus 1 and the counter minus 1.
- R10: A flag set while a run is busy is serviced only after the run ends. Among several pending sources, the lowest index goes first.
- R11: The run for source i starts at slot i*NSLOT/NSRC and proceeds through consecutive slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | NSRC | Per-source event pulse, sets the flag |
| src_clr | input | NSRC | Per-source flag clear from the processor |
| arm_set | input | NSRC | Per-source pulse setting the arm bit |
| cfg_we | input | 1 | Descriptor slot write strobe |
| cfg_slot | input | log2(NSLOT) | Slot written |
| cfg_mode | input | 8 | Mode byte written |
| cfg_sptr | input | AW | Source pointer written |
| cfg_dptr | input | AW | Destination pointer written |
| cfg_count | input | CW | Counter written |
| peek_slot | input | log2(NSLOT) | Slot read back |
| peek_mode | output | 8 | Mode byte of the peeked slot |
| peek_sptr | output | AW | Source pointer of the peeked slot |
| peek_dptr | output | AW | Destination pointer of the peeked slot |
| peek_count | output | CW | Counter of the peeked slot |
| mv_valid | output | 1 | One-cycle move strobe |
| mv_sptr | output | AW | Source address of the move |
| mv_dptr | output | AW | Destination address of the move |
| busy | output | 1 | A run is in progress |
| src_flag | output | NSRC | Source flags |
| src_arm | output | NSRC | Source arm bits |
| cpu_irq | output | NSRC | Interrupt lines to the processor |

## Verification
A wrong state register shows up at the ports almost at once. A run stuck outside idle keeps `busy` high and blocks every later request. A wrong link decision changes the number of `mv_valid` strobes within three cycles of the last move. A wrong end decision leaves the wrong mix of `src_flag`, `src_arm` and `cpu_irq` in the cycle the controller returns to idle. A bad write-back stays hidden until the slot is peeked or moved again, so the bench reads the slots back through the peek port after each run.

// File: rtl/cxc_pkg.sv
package cxc_pkg;

   localparam int MODE_W    = 8;
   localparam int LINK_BIT  = 7;
   localparam int ISEL_BIT  = 6;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_MOVE  = 2'd2,
      ST_WBACK = 2'd3
   } cxc_state_e;

   // Outcome of a finished descriptor, consumed by the source bank
   typedef enum logic [1:0] {
      END_LINK    = 2'd0,
      END_CONSUME = 2'd1,
      END_PASS    = 2'd2,
      END_EXHAUST = 2'd3
   } cxc_end_e;

endpackage

// File: rtl/cxc_desc_store.sv
module cxc_desc_store #(
   parameter int NSLOT = 16,
   parameter int AW    = 16,
   parameter int CW    = 16,
   localparam int SLW  = $clog2(NSLOT),
   localparam int MW   = cxc_pkg::MODE_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [SLW-1:0] cfg_slot,
   input  logic [MW-1:0]  cfg_mode,
   input  logic [AW-1:0]  cfg_sptr,
   input  logic [AW-1:0]  cfg_dptr,
   input  logic [CW-1:0]  cfg_count,
   input  logic           wb_we,
   input  logic [SLW-1:0] wb_slot,
   input  logic [AW-1:0]  wb_sptr,
   input  logic [AW-1:0]  wb_dptr,
   input  logic [CW-1:0]  wb_count,
   input  logic [SLW-1:0] a_slot,
   output logic [MW-1:0]  a_mode,
   output logic [AW-1:0]  a_sptr,
   output logic [AW-1:0]  a_dptr,
   output logic [CW-1:0]  a_count,
   input  logic [SLW-1:0] b_slot,
   output logic [MW-1:0]  b_mode,
   output logic [AW-1:0]  b_sptr,
   output logic [AW-1:0]  b_dptr,
   output logic [CW-1:0]  b_count
);

   logic [MW-1:0] mode_q  [NSLOT];
   logic [AW-1:0] sptr_q  [NSLOT];
   logic [AW-1:0] dptr_q  [NSLOT];
   logic [CW-1:0] count_q [NSLOT];

   // Write-back from the engine wins over a configuration write to the same slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NSLOT; s++) begin
            mode_q[s]  <= '0;
            sptr_q[s]  <= '0;
            dptr_q[s]  <= '0;
            count_q[s] <= '0;
         end
      end else begin
         for (int s = 0; s < NSLOT; s++) begin
            if (wb_we && (wb_slot == SLW'(s))) begin
               sptr_q[s]  <= wb_sptr;
               dptr_q[s]  <= wb_dptr;
               count_q[s] <= wb_count;
            end else if (cfg_we && (cfg_slot == SLW'(s))) begin
               mode_q[s]  <= cfg_mode;
               sptr_q[s]  <= cfg_sptr;
               dptr_q[s]  <= cfg_dptr;
               count_q[s] <= cfg_count;
            end
         end
      end
   end

   assign a_mode  = mode_q[a_slot];
   assign a_sptr  = sptr_q[a_slot];
   assign a_dptr  = dptr_q[a_slot];
   assign a_count = count_q[a_slot];

   assign b_mode  = mode_q[b_slot];
   assign b_sptr  = sptr_q[b_slot];
   assign b_dptr  = dptr_q[b_slot];
   assign b_count = count_q[b_slot];

endmodule

// File: rtl/cxc_src_bank.sv
module cxc_src_bank #(
   parameter int NSRC = 4,
   localparam int SW  = $clog2(NSRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_set,
   input  logic [NSRC-1:0]   src_clr,
   input  logic [NSRC-1:0]   arm_set,
   input  logic              done,
   input  logic [SW-1:0]     done_src,
   input  cxc_pkg::cxc_end_e done_kind,
   output logic [NSRC-1:0]   flag,
   output logic [NSRC-1:0]   arm,
   output logic [NSRC-1:0]   act_req,
   output logic [NSRC-1:0]   cpu_irq
);
   import cxc_pkg::*;

   logic [NSRC-1:0] pass_q;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic hit, consume, exhaust, handoff, flag_nx;

      assign hit     = done && (done_src == SW'(i));
      assign consume = hit && (done_kind == END_CONSUME);
      assign exhaust = hit && (done_kind == END_EXHAUST);
      assign handoff = hit && (done_kind == END_PASS);
      // A fresh event outranks any clear in the same cycle
      assign flag_nx = (flag[i] && !src_clr[i] && !consume) || src_set[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag[i]   <= 1'b0;
            arm[i]    <= 1'b0;
            pass_q[i] <= 1'b0;
         end else begin
            flag[i]   <= flag_nx;
            arm[i]    <= (arm[i] || arm_set[i]) && !exhaust;
            pass_q[i] <= flag_nx && (pass_q[i] || handoff);
         end
      end

      assign act_req[i] = flag[i] && arm[i] && !pass_q[i];
      assign cpu_irq[i] = flag[i] && (!arm[i] || pass_q[i]);
   end

endmodule

// File: rtl/cxc_arbiter.sv
module cxc_arbiter #(
   parameter int NSRC   = 4,
   parameter bit ARB_RR = 1'b0,
   localparam int SW    = $clog2(NSRC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] req,
   input  logic            take,
   output logic            grant_valid,
   output logic [SW-1:0]   grant_idx
);

   assign grant_valid = |req;

   if (ARB_RR) begin : g_rr
      logic [SW-1:0] ptr_q;

      always_comb begin
         grant_idx = '0;
         for (int k = NSRC - 1; k >= 0; k--) begin
            int j;
            j = int'(ptr_q) + k;
            if (j >= NSRC) j = j - NSRC;
            if (req[j]) grant_idx = SW'(j);
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ptr_q <= '0;
         else if (take)
            ptr_q <= (int'(grant_idx) == NSRC - 1) ? '0 : grant_idx + SW'(1);
      end
   end else begin : g_fixed
      logic unused_fixed;
      assign unused_fixed = clk ^ rst_n ^ take;

      always_comb begin
         grant_idx = '0;
         for (int k = NSRC - 1; k >= 0; k--)
            if (req[k]) grant_idx = SW'(k);
      end
   end

endmodule

// File: rtl/cxc_engine.sv
module cxc_engine #(
   parameter int NSRC  = 4,
   parameter int NSLOT = 16,
   parameter int AW    = 16,
   parameter int CW    = 16,
   localparam int SW   = $clog2(NSRC),
   localparam int SLW  = $clog2(NSLOT),
   localparam int SPAN = NSLOT / NSRC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grant_valid,
   input  logic [SW-1:0]     grant_idx,
   output logic              take,
   output logic [SLW-1:0]    fetch_slot,
   input  logic              f_link,
   input  logic              f_isel,
   input  logic [AW-1:0]     f_sptr,
   input  logic [AW-1:0]     f_dptr,
   input  logic [CW-1:0]     f_count,
   output logic              wb_we,
   output logic [SLW-1:0]    wb_slot,
   output logic [AW-1:0]     wb_sptr,
   output logic [AW-1:0]     wb_dptr,
   output logic [CW-1:0]     wb_count,
   output logic              mv_valid,
   output logic [AW-1:0]     mv_sptr,
   output logic [AW-1:0]     mv_dptr,
   output logic              busy,
   output logic              done,
   output logic [SW-1:0]     done_src,
   output cxc_pkg::cxc_end_e done_kind
);
   import cxc_pkg::*;

   cxc_state_e     state_q;
   logic [SW-1:0]  src_q;
   logic [SLW-1:0] slot_q;
   logic           link_q, isel_q;
   logic [AW-1:0]  sptr_q, dptr_q;
   logic [CW-1:0]  count_q;
   logic [CW-1:0]  count_nx;
   logic           last_desc;

   assign count_nx  = count_q - CW'(1);
   assign last_desc = !link_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         src_q   <= '0;
         slot_q  <= '0;
         link_q  <= 1'b0;
         isel_q  <= 1'b0;
         sptr_q  <= '0;
         dptr_q  <= '0;
         count_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (grant_valid) begin
               src_q   <= grant_idx;
               slot_q  <= SLW'(int'(grant_idx) * SPAN);
               state_q <= ST_FETCH;
            end
            ST_FETCH: begin
               link_q  <= f_link;
               isel_q  <= f_isel;
               sptr_q  <= f_sptr;
               dptr_q  <= f_dptr;
               count_q <= f_count;
               state_q <= ST_MOVE;
            end
            ST_MOVE:  state_q <= ST_WBACK;
            ST_WBACK: begin
               if (last_desc) begin
                  state_q <= ST_IDLE;
               end else begin
                  slot_q  <= slot_q + SLW'(1);
                  state_q <= ST_FETCH;
               end
            end
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign take       = (state_q == ST_IDLE) && grant_valid;
   assign busy       = (state_q != ST_IDLE);
   assign fetch_slot = slot_q;

   assign mv_valid = (state_q == ST_MOVE);
   assign mv_sptr  = sptr_q;
   assign mv_dptr  = dptr_q;

   assign wb_we    = (state_q == ST_WBACK);
   assign wb_slot  = slot_q;
   assign wb_sptr  = sptr_q + AW'(1);
   assign wb_dptr  = dptr_q + AW'(1);
   assign wb_count = count_nx;

   assign done     = (state_q == ST_WBACK) && last_desc;
   assign done_src = src_q;

   always_comb begin
      if (link_q)                done_kind = END_LINK;
      else if (count_nx == '0)   done_kind = END_EXHAUST;
      else if (isel_q)           done_kind = END_PASS;
      else                       done_kind = END_CONSUME;
   end

endmodule

// File: rtl/chain_xfer_ctrl.sv
module chain_xfer_ctrl #(
   parameter int NSRC   = 4,
   parameter int NSLOT  = 16,
   parameter int AW     = 16,
   parameter int CW     = 16,
   parameter bit ARB_RR = 1'b0,
   localparam int SLW   = $clog2(NSLOT),
   localparam int MW    = cxc_pkg::MODE_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_set,
   input  logic [NSRC-1:0] src_clr,
   input  logic [NSRC-1:0] arm_set,
   input  logic            cfg_we,
   input  logic [SLW-1:0]  cfg_slot,
   input  logic [MW-1:0]   cfg_mode,
   input  logic [AW-1:0]   cfg_sptr,
   input  logic [AW-1:0]   cfg_dptr,
   input  logic [CW-1:0]   cfg_count,
   input  logic [SLW-1:0]  peek_slot,
   output logic [MW-1:0]   peek_mode,
   output logic [AW-1:0]   peek_sptr,
   output logic [AW-1:0]   peek_dptr,
   output logic [CW-1:0]   peek_count,
   output logic            mv_valid,
   output logic [AW-1:0]   mv_sptr,
   output logic [AW-1:0]   mv_dptr,
   output logic            busy,
   output logic [NSRC-1:0] src_flag,
   output logic [NSRC-1:0] src_arm,
   output logic [NSRC-1:0] cpu_irq
);
   import cxc_pkg::*;

   localparam int SW = $clog2(NSRC);

   if (NSRC < 2) begin : g_bad_nsrc
      $error("chain_xfer_ctrl: NSRC must be at least 2");
   end
   if ((NSLOT < 2) || ((NSLOT & (NSLOT - 1)) != 0)) begin : g_bad_nslot
      $error("chain_xfer_ctrl: NSLOT must be a power of two");
   end
   if ((NSLOT % NSRC) != 0) begin : g_bad_span
      $error("chain_xfer_ctrl: NSLOT must be a multiple of NSRC");
   end
   if ((CW < 2) || (AW < 2)) begin : g_bad_width
      $error("chain_xfer_ctrl: AW and CW must be at least 2");
   end

   logic [NSRC-1:0] act_req;
   logic            grant_valid, take;
   logic [SW-1:0]   grant_idx;
   logic [SLW-1:0]  fetch_slot, wb_slot;
   logic [MW-1:0]   f_mode;
   logic [AW-1:0]   f_sptr, f_dptr, wb_sptr, wb_dptr;
   logic [CW-1:0]   f_count, wb_count;
   logic            wb_we, done;
   logic [SW-1:0]   done_src;
   cxc_end_e        done_kind;
   logic            unused_resv;

   assign unused_resv = ^f_mode[ISEL_BIT-1:0];

   cxc_desc_store #(.NSLOT(NSLOT), .AW(AW), .CW(CW)) u_store (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_mode(cfg_mode),
      .cfg_sptr(cfg_sptr), .cfg_dptr(cfg_dptr), .cfg_count(cfg_count),
      .wb_we(wb_we), .wb_slot(wb_slot), .wb_sptr(wb_sptr),
      .wb_dptr(wb_dptr), .wb_count(wb_count),
      .a_slot(fetch_slot), .a_mode(f_mode), .a_sptr(f_sptr),
      .a_dptr(f_dptr), .a_count(f_count),
      .b_slot(peek_slot), .b_mode(peek_mode), .b_sptr(peek_sptr),
      .b_dptr(peek_dptr), .b_count(peek_count)
   );

   cxc_src_bank #(.NSRC(NSRC)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .src_set(src_set), .src_clr(src_clr), .arm_set(arm_set),
      .done(done), .done_src(done_src), .done_kind(done_kind),
      .flag(src_flag), .arm(src_arm), .act_req(act_req), .cpu_irq(cpu_irq)
   );

   cxc_arbiter #(.NSRC(NSRC), .ARB_RR(ARB_RR)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(act_req), .take(take),
      .grant_valid(grant_valid), .grant_idx(grant_idx)
   );

   cxc_engine #(.NSRC(NSRC), .NSLOT(NSLOT), .AW(AW), .CW(CW)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .grant_valid(grant_valid), .grant_idx(grant_idx), .take(take),
      .fetch_slot(fetch_slot),
      .f_link(f_mode[LINK_BIT]), .f_isel(f_mode[ISEL_BIT]),
      .f_sptr(f_sptr), .f_dptr(f_dptr), .f_count(f_count),
      .wb_we(wb_we), .wb_slot(wb_slot), .wb_sptr(wb_sptr),
      .wb_dptr(wb_dptr), .wb_count(wb_count),
      .mv_valid(mv_valid), .mv_sptr(mv_sptr), .mv_dptr(mv_dptr),
      .busy(busy), .done(done), .done_src(done_src), .done_kind(done_kind)
   );

endmodule

// File: rtl/cxc_checker.sv
module cxc_checker #(
   parameter int NSRC = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            mv_valid,
   input logic            busy,
   input logic [NSRC-1:0] src_clr,
   input logic [NSRC-1:0] src_flag,
   input logic [NSRC-1:0] src_arm,
   input logic [NSRC-1:0] cpu_irq
);

   // R4: a move is only ever issued inside a run
   p_move_in_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mv_valid |-> busy);

   // R5: each linked descriptor needs its own fetch, so moves never sit back to back
   p_move_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mv_valid |=> !mv_valid);

   // R7: an interrupt line is never raised without its source flag
   p_irq_has_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((cpu_irq & ~src_flag) == '0));

   // R8: disarming at exhaustion keeps the flag set
   p_disarm_keeps_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(src_arm) & ~src_arm & ~src_flag & ~$past(src_clr)) == '0));

   // R6: the controller clears a flag only at the end of a run
   p_flag_drop_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(src_flag) & ~src_flag & ~$past(src_clr))) |-> $past(busy));

endmodule

bind chain_xfer_ctrl cxc_checker #(.NSRC(NSRC)) u_cxc_checker (
   .clk(clk), .rst_n(rst_n), .mv_valid(mv_valid), .busy(busy),
   .src_clr(src_clr), .src_flag(src_flag), .src_arm(src_arm), .cpu_irq(cpu_irq)
);

// File: tb/sim_chain_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_chain_xfer_ctrl;

   localparam int NSRC  = 4;
   localparam int NSLOT = 16;
   localparam int AW    = 16;
   localparam int CW    = 16;
   localparam int SPAN  = NSLOT / NSRC;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [3:0]      src_set = '0, src_clr = '0, arm_set = '0;
   logic            cfg_we = 1'b0;
   logic [3:0]      cfg_slot = '0, peek_slot = '0;
   logic [7:0]      cfg_mode = '0;
   logic [15:0]     cfg_sptr = '0, cfg_dptr = '0, cfg_count = '0;
   logic [7:0]      peek_mode;
   logic [15:0]     peek_sptr, peek_dptr, peek_count;
   logic            mv_valid, busy;
   logic [15:0]     mv_sptr, mv_dptr;
   logic [3:0]      src_flag, src_arm, cpu_irq;

   int n_tests = 0;
   int n_fail  = 0;
   int mv_cnt  = 0;
   logic [15:0] mv_log [64];

   always #2 clk = ~clk;

   chain_xfer_ctrl #(.NSRC(NSRC), .NSLOT(NSLOT), .AW(AW), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
      .arm_set(arm_set), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
      .cfg_mode(cfg_mode), .cfg_sptr(cfg_sptr), .cfg_dptr(cfg_dptr),
      .cfg_count(cfg_count), .peek_slot(peek_slot), .peek_mode(peek_mode),
      .peek_sptr(peek_sptr), .peek_dptr(peek_dptr), .peek_count(peek_count),
      .mv_valid(mv_valid), .mv_sptr(mv_sptr), .mv_dptr(mv_dptr),
      .busy(busy), .src_flag(src_flag), .src_arm(src_arm), .cpu_irq(cpu_irq)
   );

   // Move monitor: record source address of every strobe
   always @(negedge clk) begin
      if (mv_valid) begin
         mv_log[mv_cnt % 64] = mv_sptr;
         mv_cnt = mv_cnt + 1;
      end
   end

   typedef struct packed {
      logic [1:0] src;
      logic [7:0] m0;
      logic [3:0] c0;
      logic [7:0] m1;
      logic [3:0] c1;
      logic [1:0] moves;
      logic       fl;
      logic       arm;
      logic       irq;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 8'h00, 4'd3, 8'h00, 4'd0, 2'd1, 1'b0, 1'b1, 1'b0}, // R4 R6 consume
      '{2'd1, 8'h40, 4'd3, 8'h00, 4'd0, 2'd1, 1'b1, 1'b1, 1'b1}, // R7 pass
      '{2'd2, 8'h00, 4'd1, 8'h00, 4'd0, 2'd1, 1'b1, 1'b0, 1'b1}, // R8 exhaust
      '{2'd3, 8'h80, 4'd1, 8'h00, 4'd5, 2'd2, 1'b0, 1'b1, 1'b0}, // R5 link hits zero
      '{2'd0, 8'h3F, 4'd4, 8'h00, 4'd0, 2'd1, 1'b0, 1'b1, 1'b0}, // R3 reserved bits
      '{2'd1, 8'hC0, 4'd2, 8'h40, 4'd1, 2'd2, 1'b1, 1'b0, 1'b1}, // R5 R8 link isel ignored
      '{2'd2, 8'h80, 4'd9, 8'h40, 4'd9, 2'd2, 1'b1, 1'b1, 1'b1}  // R5 R7 pass after link
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   task automatic prog(input int slot, input logic [7:0] mode, input logic [15:0] cnt);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_slot  = 4'(slot);
      cfg_mode  = mode;
      cfg_sptr  = 16'h1000 + 16'(slot * 16);
      cfg_dptr  = 16'h8000 + 16'(slot * 16);
      cfg_count = cnt;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic pulse_set(input logic [3:0] m);
      @(negedge clk); src_set = m; @(negedge clk); src_set = '0;
   endtask

   task automatic pulse_clr(input logic [3:0] m);
      @(negedge clk); src_clr = m; @(negedge clk); src_clr = '0;
   endtask

   task automatic pulse_arm(input logic [3:0] m);
      @(negedge clk); arm_set = m; @(negedge clk); arm_set = '0;
   endtask

   task automatic wait_idle();
      int quiet = 0;
      for (int k = 0; k < 500 && quiet < 4; k++) begin
         @(negedge clk);
         quiet = busy ? 0 : quiet + 1;
      end
   endtask

   task automatic peek(input int slot);
      @(negedge clk);
      peek_slot = 4'(slot);
      #1;
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk_eq("R1 busy", int'(busy), 0);
      chk_eq("R1 mv_valid", int'(mv_valid), 0);
      chk_eq("R1 flags", int'(src_flag), 0);
      chk_eq("R1 arm", int'(src_arm), 0);
      chk_eq("R1 irq", int'(cpu_irq), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Vector table
      for (int v = 0; v < NV; v++) begin
         int b;
         logic [3:0] m;
         b = int'(VECS[v].src) * SPAN;
         m = 4'(1 << VECS[v].src);
         pulse_clr(4'hF);
         pulse_arm(m);
         prog(b, VECS[v].m0, 16'(VECS[v].c0));
         prog(b + 1, VECS[v].m1, 16'(VECS[v].c1));
         base = mv_cnt;
         pulse_set(m);
         wait_idle();
         chk_eq($sformatf("R4/R5 vec%0d moves", v), mv_cnt - base, int'(VECS[v].moves));
         chk_eq($sformatf("R6/R7/R8 vec%0d flag", v), int'(src_flag[VECS[v].src]), int'(VECS[v].fl));
         chk_eq($sformatf("R8 vec%0d arm", v), int'(src_arm[VECS[v].src]), int'(VECS[v].arm));
         chk_eq($sformatf("R6/R7 vec%0d irq", v), int'(cpu_irq[VECS[v].src]), int'(VECS[v].irq));
         chk_eq($sformatf("R11 vec%0d first slot", v), int'(mv_log[base % 64]), 16'h1000 + b * 16);
      end

      // R9: write-back of pointers and counter
      pulse_clr(4'hF);
      pulse_arm(4'b0100);
      prog(8, 8'h00, 16'd6);
      base = mv_cnt;
      pulse_set(4'b0100);
      wait_idle();
      chk_eq("R9 move sptr", int'(mv_log[base % 64]), 16'h1080);
      peek(8);
      chk_eq("R9 count", int'(peek_count), 5);
      chk_eq("R9 sptr", int'(peek_sptr), 16'h1081);
      chk_eq("R9 dptr", int'(peek_dptr), 16'h8081);

      // R5: link counter reaching zero does not end or disarm
      pulse_clr(4'hF);
      pulse_arm(4'b1000);
      prog(12, 8'h80, 16'd1);
      prog(13, 8'h00, 16'd5);
      base = mv_cnt;
      pulse_set(4'b1000);
      wait_idle();
      chk_eq("R5 link moves", mv_cnt - base, 2);
      peek(12);
      chk_eq("R5 link count", int'(peek_count), 0);
      peek(13);
      chk_eq("R5 tail count", int'(peek_count), 4);
      chk_eq("R5 arm kept", int'(src_arm[3]), 1);

      // R8 then R2: exhausted source stays disarmed, a new event interrupts
      pulse_clr(4'hF);
      pulse_arm(4'b0010);
      prog(4, 8'h00, 16'd1);
      pulse_set(4'b0010);
      wait_idle();
      chk_eq("R8 disarmed", int'(src_arm[1]), 0);
      pulse_clr(4'b0010);
      base = mv_cnt;
      pulse_set(4'b0010);
      wait_idle();
      chk_eq("R2 no move when disarmed", mv_cnt - base, 0);
      chk_eq("R2 irq when disarmed", int'(cpu_irq[1]), 1);

      // R10 R11: pending sources wait, lowest index first
      pulse_clr(4'hF);
      pulse_arm(4'b1011);
      prog(12, 8'h80, 16'd9);
      prog(13, 8'h00, 16'd9);
      prog(0, 8'h00, 16'd9);
      prog(4, 8'h00, 16'd9);
      base = mv_cnt;
      pulse_set(4'b1000);
      repeat (2) @(negedge clk);
      chk_eq("R10 busy during chain", int'(busy), 1);
      pulse_set(4'b0011);
      wait_idle();
      chk_eq("R10 total moves", mv_cnt - base, 4);
      chk_eq("R10 order 0", int'(mv_log[base % 64]), 16'h10C0);
      chk_eq("R10 order 1", int'(mv_log[(base + 1) % 64]), 16'h10D0);
      chk_eq("R10 order 2", int'(mv_log[(base + 2) % 64]), 16'h1000);
      chk_eq("R10 order 3", int'(mv_log[(base + 3) % 64]), 16'h1040);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule